// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox Pair

Two single-word mailboxes let two independently clocked ports exchange a word without going through the data FIFO that sits beside them. One mailbox carries a word from port A to port B. The other carries a word from port B to port A. A port writes the mailbox it sends through and reads the mailbox it receives from. Its access strobe is made of chip select, enable, mailbox select and a direction bit.

Each mailbox has a mail-present flag in the receiving port's clock domain. A write in the sender's domain flips a request toggle. The receiver brings that toggle in through a synchroniser and raises the flag. A read by the receiver lowers the flag and flips an acknowledge toggle back toward the sender. Until that acknowledge arrives, the sender holds the stored word and ignores further writes, so unread mail is never overwritten.

The control pins are plain level strobes sampled on each port's rising edge. The mail flag is the only form of back-pressure. A sender that writes while its earlier word is still unacknowledged has the write dropped without notice. The receiver should read only while its flag is high.

Top module: `mbox_pair_xclk`

## Requirements
- R1: While `rst_n` is low, and after it returns high, both mail flags are 0 and both read-data outputs are 0. A mailbox read issued after reset and before any accepted write returns 0.
- R2: Port A stores `a_wdata` into the A-to-B mailbox only on a rising `clk_a` edge where `a_cs`, `a_en`, `a_mbx` and `a_wr` are all 1. If any one of them is 0, `b_mail` stays 0.
- R3: Port B stores `b_wdata` into the B-to-A mailbox only on a rising `clk_b` edge where `b_cs`, `b_en`, `b_mbx` and `b_wr` are all 1. An accepted write raises `a_mail`, and the word can then be read on port A.
- R4: After an accepted write, the receiver's flag goes high no earlier than SYNC_STAGES and no later than SYNC_STAGES+1 rising edges of the receiver's clock.
- R5: A read strobe (`cs`, `en`, `mbx` all 1 and `wr` 0) loads the mailbox word into the port's read-data output at that rising edge. Read data changes at no other time. A read while the flag is high lowers the flag at that same edge.
- R6: A write strobe while the sender's previous word is still unacknowledged is ignored. The stored word is kept, and the next read returns the older word.
- R7: An access with `mbx` 0 or `cs` 0 leaves the flag unchanged. A mailbox read while the flag is 0 returns the word last held and does not raise the flag.
- R8: The two directions are independent. Writes on both ports in overlapping cycles are both accepted, and each word is delivered to the opposite port.
- R9: With SYNC_STAGES = 2, a write issued on the fourth sender edge after the receiver's clearing read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock, free running |
| clk_b | input | 1 | Port B clock, free running, any phase or frequency relative to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs | input | 1 | Port A chip select, active high |
| a_en | input | 1 | Port A enable, active high |
| a_mbx | input | 1 | Port A mailbox select (1 = mailbox, 0 = FIFO path) |
| a_wr | input | 1 | Port A direction (1 = write, 0 = read) |
| a_wdata | input | DATA_W | Word written to the A-to-B mailbox |
| a_rdata | output | DATA_W | Word read from the B-to-A mailbox, registered |
| a_mail | output | 1 | Mail waiting in the B-to-A mailbox (clk_a domain) |
| b_cs | input | 1 | Port B chip select, active high |
| b_en | input | 1 | Port B enable, active high |
| b_mbx | input | 1 | Port B mailbox select (1 = mailbox, 0 = FIFO path) |
| b_wr | input | 1 | Port B direction (1 = write, 0 = read) |
| b_wdata | input | DATA_W | Word written to the B-to-A mailbox |
| b_rdata | output | DATA_W | Word read from the A-to-B mailbox, registered |
| b_mail | output | 1 | Mail waiting in the A-to-B mailbox (clk_b domain) |

## Verification
Two events can land in the same cycle. One is both ports writing their outgoing mailboxes at once. The other is a sender write arriving while the receiver's clearing read is still travelling back as an acknowledge. The bench forks simultaneous writes on A and B and then reads both ports together, expecting each to deliver the other's word. It also writes again right after a pending write, and again at the edge bound from R9. Each is judged by comparing what the receiver reads against a queue of words the sender was expected to have had accepted.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned MBX_W_DEF = 36;

  // Per-port access strobe bundle
  typedef struct packed {
    logic cs;
    logic en;
    logic sel;
    logic wr;
  } mbx_ctl_t;

  function automatic logic ctl_write(input mbx_ctl_t c);
    return c.cs & c.en & c.sel & c.wr;
  endfunction

  function automatic logic ctl_read(input mbx_ctl_t c);
    return c.cs & c.en & c.sel & ~c.wr;
  endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_sender.sv
module mbx_sender #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         ack_tgl_i,
  output logic         req_tgl_o,
  output logic [W-1:0] data_o
);

  logic         ack_s;
  logic         req_q;
  logic [W-1:0] data_q;
  logic         pending;
  logic         accept;

  mbx_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_tgl_i),
    .q     (ack_s)
  );

  // Word in flight until the acknowledge toggle catches up
  assign pending = req_q ^ ack_s;
  assign accept  = wr_req & ~pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      req_q  <= ~req_q;
      data_q <= wdata;
    end
  end

  assign req_tgl_o = req_q;
  assign data_o    = data_q;

  // R6: unread word must not move while it is pending
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> $stable(data_q));

  // R2: no request without a write strobe
  p_idle_no_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(req_q));

endmodule

// File: rtl/mbx_receiver.sv
module mbx_receiver #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_req,
  input  logic         req_tgl_i,
  input  logic [W-1:0] data_i,
  output logic         ack_tgl_o,
  output logic         flag_o,
  output logic [W-1:0] rdata_o
);

  logic         req_s;
  logic         ack_q;
  logic [W-1:0] rdata_q;
  logic         flag;

  mbx_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tgl_i),
    .q     (req_s)
  );

  assign flag = req_s ^ ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else if (rd_req) begin
      rdata_q <= data_i;
      if (flag) ack_q <= req_s;
    end
  end

  assign ack_tgl_o = ack_q;
  assign flag_o    = flag;
  assign rdata_o   = rdata_q;

  // R5: a read of waiting mail drops the flag at once
  p_flag_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && flag) |=> !flag_o);

  // R5: read data moves only on a read strobe
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata_o));

endmodule

// File: rtl/mbox_pair_xclk.sv
module mbox_pair_xclk
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_cs,
  input  logic              a_en,
  input  logic              a_mbx,
  input  logic              a_wr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_mail,
  input  logic              b_cs,
  input  logic              b_en,
  input  logic              b_mbx,
  input  logic              b_wr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_mail
);

  localparam int unsigned LANES = 2;  // lane 0: A to B, lane 1: B to A

  mbx_ctl_t ctl_a, ctl_b;
  assign ctl_a = '{cs: a_cs, en: a_en, sel: a_mbx, wr: a_wr};
  assign ctl_b = '{cs: b_cs, en: b_en, sel: b_mbx, wr: b_wr};

  logic [LANES-1:0] tx_clk, rx_clk, wr_req, rd_req;
  logic [LANES-1:0] req_tgl, ack_tgl, flag;
  logic [DATA_W-1:0] wdata_l [LANES];
  logic [DATA_W-1:0] held_l  [LANES];
  logic [DATA_W-1:0] rdata_l [LANES];

  assign tx_clk     = {clk_b, clk_a};
  assign rx_clk     = {clk_a, clk_b};
  assign wr_req     = {ctl_write(ctl_b), ctl_write(ctl_a)};
  assign rd_req     = {ctl_read(ctl_a),  ctl_read(ctl_b)};
  assign wdata_l[0] = a_wdata;
  assign wdata_l[1] = b_wdata;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mbx_sender #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_tx (
      .clk       (tx_clk[g]),
      .rst_n     (rst_n),
      .wr_req    (wr_req[g]),
      .wdata     (wdata_l[g]),
      .ack_tgl_i (ack_tgl[g]),
      .req_tgl_o (req_tgl[g]),
      .data_o    (held_l[g])
    );

    mbx_receiver #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_rx (
      .clk       (rx_clk[g]),
      .rst_n     (rst_n),
      .rd_req    (rd_req[g]),
      .req_tgl_i (req_tgl[g]),
      .data_i    (held_l[g]),
      .ack_tgl_o (ack_tgl[g]),
      .flag_o    (flag[g]),
      .rdata_o   (rdata_l[g])
    );
  end

  assign b_mail  = flag[0];
  assign b_rdata = rdata_l[0];
  assign a_mail  = flag[1];
  assign a_rdata = rdata_l[1];

endmodule

// File: tb/mbox_pair_xclk_tb_top.sv
module mbox_pair_xclk_tb_top;

  localparam int unsigned W = 36;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic a_cs = 0, a_en = 0, a_mbx = 0, a_wr = 0;
  logic b_cs = 0, b_en = 0, b_mbx = 0, b_wr = 0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_mail, b_mail;

  int n_chk = 0;
  int n_err = 0;
  string tag = "R1";
  logic [W-1:0] q_ab[$];
  logic [W-1:0] q_ba[$];
  logic [W-1:0] last_ab = '0;
  logic [W-1:0] last_ba = '0;
  logic had_a, had_b;
  bit mon_on = 1'b0;

  // 50 MHz on port A; port B at 30 ns with a phase offset
  always #10 clk_a = ~clk_a;
  initial begin
    #10;
    forever #15 clk_b = ~clk_b;
  end

  mbox_pair_xclk dut_i (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs(a_cs), .a_en(a_en), .a_mbx(a_mbx), .a_wr(a_wr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_mail(a_mail),
    .b_cs(b_cs), .b_en(b_en), .b_mbx(b_mbx), .b_wr(b_wr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_mail(b_mail)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Drivers
  task automatic a_op(input logic cs, input logic en, input logic sel, input logic wr,
                      input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs = cs; a_en = en; a_mbx = sel; a_wr = wr; a_wdata = d;
    @(posedge clk_a); #1;
    a_cs = 0; a_en = 0; a_mbx = 0; a_wr = 0;
  endtask

  task automatic b_op(input logic cs, input logic en, input logic sel, input logic wr,
                      input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs = cs; b_en = en; b_mbx = sel; b_wr = wr; b_wdata = d;
    @(posedge clk_b); #1;
    b_cs = 0; b_en = 0; b_mbx = 0; b_wr = 0;
  endtask

  task automatic a_write(input logic [W-1:0] d, input bit expect_ok);
    if (expect_ok) q_ab.push_back(d);
    a_op(1, 1, 1, 1, d);
  endtask

  task automatic b_write(input logic [W-1:0] d, input bit expect_ok);
    if (expect_ok) q_ba.push_back(d);
    b_op(1, 1, 1, 1, d);
  endtask

  task automatic wait_b_flag(output int n);
    n = 0;
    while (!b_mail && n < 8) begin
      @(posedge clk_b); #1; n++;
    end
  endtask

  task automatic wait_a_flag(output int n);
    n = 0;
    while (!a_mail && n < 8) begin
      @(posedge clk_a); #1; n++;
    end
  endtask

  // Monitors: compare every mailbox read against the scoreboard
  initial forever begin
    @(negedge clk_b); #2;
    if (mon_on && b_cs && b_en && b_mbx && !b_wr) begin
      had_b = b_mail;
      @(posedge clk_b); #1;
      if (had_b && q_ab.size() > 0) last_ab = q_ab.pop_front();
      chk({tag, " B-read"}, b_rdata, last_ab);
    end
  end

  initial forever begin
    @(negedge clk_a); #2;
    if (mon_on && a_cs && a_en && a_mbx && !a_wr) begin
      had_a = a_mail;
      @(posedge clk_a); #1;
      if (had_a && q_ba.size() > 0) last_ba = q_ba.pop_front();
      chk({tag, " A-read"}, a_rdata, last_ba);
    end
  end

  initial begin
    #(64'd200000 * 64'd20);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic ab_round(input logic [W-1:0] d, input string t);
    int n;
    tag = t;
    a_write(d, 1);
    wait_b_flag(n);
    chk({t, " flag"}, {35'd0, b_mail}, 36'd1);
    b_op(1, 1, 1, 0, '0);
    chk({t, " clear"}, {35'd0, b_mail}, 36'd0);
    repeat (4) @(posedge clk_a);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk_b);
    @(negedge clk_a); #3;
    chk("R1 flag B in reset", {35'd0, b_mail}, 36'd0);
    chk("R1 rdata B in reset", b_rdata, '0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    #1;
    chk("R1 flag A", {35'd0, a_mail}, 36'd0);
    chk("R1 flag B", {35'd0, b_mail}, 36'd0);
    chk("R1 rdata A", a_rdata, '0);
    tag = "R1";
    b_op(1, 1, 1, 0, '0);
    a_op(1, 1, 1, 0, '0);

    // R2: each missing qualifier blocks the write
    tag = "R2";
    for (int i = 0; i < 4; i++) begin
      logic [3:0] m;
      m = 4'b1111 ^ (4'b1 << i);
      a_op(m[3], m[2], m[1], m[0], 36'hBAD_0000 + i);
      repeat (5) @(posedge clk_b); #1;
      chk("R2 qualifier", {35'd0, b_mail}, 36'd0);
    end

    // R4: flag latency
    tag = "R4";
    a_write(36'h9_ABCD_1234, 1);
    wait_b_flag(n);
    chk("R4 latency in range", {35'd0, (n >= 2 && n <= 3)}, 36'd1);

    // R6: write while pending is dropped
    tag = "R6";
    a_write(36'h1_1111_1111, 0);
    // R7: non-mailbox or deselected access keeps the flag
    b_op(1, 1, 0, 0, '0);
    b_op(0, 1, 1, 0, '0);
    repeat (2) @(posedge clk_b); #1;
    chk("R7 flag kept", {35'd0, b_mail}, 36'd1);
    tag = "R6/R5";
    b_op(1, 1, 1, 0, '0);
    chk("R5 flag cleared", {35'd0, b_mail}, 36'd0);

    // R9: write after acknowledge return
    repeat (3) @(posedge clk_a);
    tag = "R9";
    a_write(36'h5_0F0F_A5A5, 1);
    wait_b_flag(n);
    chk("R9 accepted", {35'd0, b_mail}, 36'd1);
    b_op(1, 1, 1, 0, '0);
    // R7: read with no mail returns held word, flag stays low
    tag = "R7";
    repeat (4) @(posedge clk_b);
    b_op(1, 1, 1, 0, '0);
    repeat (3) @(posedge clk_b); #1;
    chk("R7 no spurious flag", {35'd0, b_mail}, 36'd0);

    // R3: B to A direction
    tag = "R3";
    b_op(1, 0, 1, 1, 36'h7_7777_0000);
    repeat (5) @(posedge clk_a); #1;
    chk("R3 enable low blocks", {35'd0, a_mail}, 36'd0);
    b_write(36'h3_CAFE_BEEF, 1);
    wait_a_flag(n);
    chk("R3 flag A", {35'd0, a_mail}, 36'd1);
    chk("R4 latency A in range", {35'd0, (n >= 2 && n <= 3)}, 36'd1);
    a_op(1, 1, 1, 0, '0);
    chk("R3 flag A cleared", {35'd0, a_mail}, 36'd0);
    repeat (4) @(posedge clk_b);

    // R8: both directions at once
    tag = "R8";
    fork
      a_write(36'hA_0000_0001, 1);
      b_write(36'hB_0000_0002, 1);
    join
    repeat (4) @(posedge clk_b); #1;
    chk("R8 flag A", {35'd0, a_mail}, 36'd1);
    chk("R8 flag B", {35'd0, b_mail}, 36'd1);
    fork
      a_op(1, 1, 1, 0, '0);
      b_op(1, 1, 1, 0, '0);
    join
    repeat (4) @(posedge clk_b);

    // R5: data patterns
    ab_round('1, "R5 ones");
    ab_round('0, "R5 zeros");
    ab_round(36'hA_5A5A_5A5A, "R5 alt");

    // R1: reset with mail pending
    tag = "R1";
    a_write(36'hD_EAD0_BEEF, 1);
    wait_b_flag(n);
    @(negedge clk_a); #3;
    rst_n = 1'b0;
    #1;
    chk("R1 flag cleared by reset", {35'd0, b_mail}, 36'd0);
    q_ab.delete(); q_ba.delete();
    last_ab = '0; last_ba = '0;
    @(negedge clk_a); #3;
    rst_n = 1'b1;
    repeat (3) @(posedge clk_b); #1;
    chk("R1 flag after reset", {35'd0, b_mail}, 36'd0);
    b_op(1, 1, 1, 0, '0);

    repeat (4) @(posedge clk_b);
    summary();
  end

endmodule